// File: doc/BRIEF.md
# Display RAM Address Counter and Cursor Unit

This block tracks where the next character-display access lands. It takes instructions that an upstream stage has already decoded: clear, home, entry mode, cursor or display shift, line-mode select, the two address-set forms and a data access strobe. From these it keeps the address counter (AC), the RAM it points into (display RAM or the small glyph RAM), the step direction, the auto-shift enable, the one-line or two-line mode and a display scroll offset.

For each accepted data access it issues one RAM strobe with the address that applied before the access, and then steps the AC. In two-line mode the step jumps between the split line ranges instead of counting straight through. A clear instruction blanks the whole display RAM with a sweep of write strobes that carry a fill-with-space flag. Every accepted instruction holds a busy flag for a fixed number of cycles, and instructions that arrive while busy is high are dropped.

Top module: `disp_addr_ctr`

## Requirements
- R1: After reset, ac_out is 0, busy is 0, disp_ofs is 0, ram_we, ram_re and fill_blank are 0, the target is display RAM, stepping is upward, auto-shift is off and one-line mode is selected.
- R2: An instruction is taken only on a rising clock edge where cmd_valid is 1 and busy is 0. busy then stays high for BUSY_CYCLES cycles, or for 80+BUSY_CYCLES cycles after a clear. An instruction offered while busy is high changes neither ac_out nor any RAM strobe.
- R3: cmd_op codes are: 0 clear, 1 home, 2 entry mode, 3 shift, 4 line mode, 5 glyph-RAM address set, 6 display-RAM address set, 7 data access. For entry mode, cmd_arg[1] selects upward stepping and cmd_arg[0] enables auto-shift.
- R4: Op 7 with cmd_arg[0]=0 is a write and with cmd_arg[0]=1 is a read. In the cycle after acceptance, exactly one of ram_we or ram_re is high, for one cycle. ram_addr then holds the AC from before the access, and ram_cg holds the target. The AC then moves by one in the entry-mode direction.
- R5: In one-line mode on display RAM, stepping up from 0x4F or above gives 0x00, stepping down from 0x00 gives 0x4F, and any other step is ±1.
- R6: In two-line mode on display RAM, up from 0x27 gives 0x40, up from 0x67 gives 0x00, down from 0x40 gives 0x27, down from 0x00 gives 0x67, and any other step is ±1 modulo 128.
- R7: Op 5 selects glyph RAM and loads AC with {0,cmd_arg[5:0]}; steps on glyph RAM wrap modulo 64. Op 6 selects display RAM and loads AC with cmd_arg[6:0].
- R8: Clear sets AC to 0, selects display RAM, forces upward stepping and sets disp_ofs to 0. From the cycle after acceptance it raises ram_we and fill_blank for 80 consecutive cycles, with ram_addr going 0,1,…,79 and ram_cg at 0.
- R9: Home sets AC and disp_ofs to 0 and selects display RAM, and raises no RAM strobe.
- R10: Op 3 uses cmd_arg[1] (display/cursor) and cmd_arg[0] (right/left). 00 steps AC down, 01 steps it up, 10 adds one to disp_ofs, 11 subtracts one. The offset wraps modulo 40 in two-line mode and 80 in one-line mode. A display shift leaves AC unchanged.
- R11: With auto-shift on, a write to display RAM also moves disp_ofs: +1 when stepping up, −1 when stepping down. Reads and glyph-RAM writes leave it alone.
- R12: Op 4 loads two-line mode from cmd_arg[0] and sets disp_ofs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Decoded instruction present |
| cmd_op | input | 3 | Instruction code |
| cmd_arg | input | 7 | Instruction argument field |
| busy | output | 1 | Instruction in progress; new ones are dropped |
| ac_out | output | 7 | Address counter for status reads |
| ram_addr | output | 7 | RAM address of the current strobe |
| ram_cg | output | 1 | Strobe targets glyph RAM (1) or display RAM (0) |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| fill_blank | output | 1 | Write data must be the space code 0x20 |
| disp_ofs | output | 7 | Display scroll offset |

## Verification
Every result of an accepted instruction appears one clock after its accepting edge. This covers the AC, the offset, the busy rise and the data strobes. The clear sweep then advances one address per cycle from that same cycle, and busy falls exactly BUSY_CYCLES (or 80+BUSY_CYCLES) samples after the first one. The bench drives inputs on falling edges and samples half a cycle after the accepting edge. It then counts falling-edge samples while busy is high, checks the sweep address against that count, and re-checks ac_out once busy drops. This final check catches any instruction that slipped in during the busy window.

// File: rtl/dac_pkg.sv
package dac_pkg;
  typedef enum logic [2:0] {
    OP_CLEAR  = 3'd0,
    OP_HOME   = 3'd1,
    OP_ENTRY  = 3'd2,
    OP_SHIFT  = 3'd3,
    OP_LINES  = 3'd4,
    OP_SET_CG = 3'd5,
    OP_SET_DD = 3'd6,
    OP_DATA   = 3'd7
  } dac_op_e;

  localparam int AC_W     = 7;
  localparam int DD_COUNT = 80;
  localparam logic [6:0] ONE_LAST = 7'h4F;
  localparam logic [6:0] L1_LAST  = 7'h27;
  localparam logic [6:0] L2_FIRST = 7'h40;
  localparam logic [6:0] L2_LAST  = 7'h67;
  localparam logic [6:0] LEN_TWO  = 7'd40;
  localparam logic [6:0] LEN_ONE  = 7'd80;

  // next address counter value for one step
  function automatic logic [6:0] ac_step(logic [6:0] a, logic up, logic two, logic cg);
    logic [5:0] g;
    if (cg) begin
      g = up ? (a[5:0] + 6'd1) : (a[5:0] - 6'd1);
      return {1'b0, g};
    end
    if (two) begin
      if (up) return (a == L1_LAST) ? L2_FIRST : (a == L2_LAST) ? 7'h00 : a + 7'd1;
      else    return (a == L2_FIRST) ? L1_LAST : (a == 7'h00) ? L2_LAST : a - 7'd1;
    end
    if (up) return (a >= ONE_LAST) ? 7'h00 : a + 7'd1;
    return (a == 7'h00) ? ONE_LAST : a - 7'd1;
  endfunction

  // scroll offset step, modulo the line length
  function automatic logic [6:0] ofs_step(logic [6:0] o, logic left, logic two);
    logic [6:0] len;
    len = two ? LEN_TWO : LEN_ONE;
    if (left) return (o == len - 7'd1) ? 7'd0 : o + 7'd1;
    return (o == 7'd0) ? len - 7'd1 : o - 7'd1;
  endfunction
endpackage

// File: rtl/dac_busy_timer.sv
module dac_busy_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= load;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && load != '0) |=> busy); // R2
endmodule

// File: rtl/dac_clear_sweep.sv
module dac_clear_sweep #(
  parameter int DEPTH = 80,
  parameter int W     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         active,
  output logic [W-1:0] idx
);
  localparam logic [W-1:0] LAST = W'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active) begin
      if (idx == LAST) active <= 1'b0;
      else             idx    <= idx + 1'b1;
    end
  end

  AST_SWEEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start && idx != LAST) |=> (active && idx == $past(idx) + W'(1))); // R8
endmodule

// File: rtl/dac_ac_core.sv
module dac_ac_core
  import dac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  dac_op_e         op,
  input  logic [6:0]      arg,
  output logic [AC_W-1:0] ac,
  output logic            cg,
  output logic [6:0]      ofs
);
  logic inc, sh, two;

  // named events for the checks below
  logic clr_acc, dshift_acc, data_step;
  assign clr_acc    = acc && (op == OP_CLEAR);
  assign dshift_acc = acc && (op == OP_SHIFT) && arg[1];
  assign data_step  = acc && (op == OP_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac  <= '0;
      cg  <= 1'b0;
      inc <= 1'b1;
      sh  <= 1'b0;
      two <= 1'b0;
      ofs <= '0;
    end else if (acc) begin
      case (op)
        OP_CLEAR: begin
          ac  <= '0;
          cg  <= 1'b0;
          inc <= 1'b1;
          ofs <= '0;
        end
        OP_HOME: begin
          ac  <= '0;
          cg  <= 1'b0;
          ofs <= '0;
        end
        OP_ENTRY: begin
          inc <= arg[1];
          sh  <= arg[0];
        end
        OP_SHIFT: begin
          if (!arg[1]) ac  <= ac_step(ac, arg[0], two, cg);
          else         ofs <= ofs_step(ofs, !arg[0], two);
        end
        OP_LINES: begin
          two <= arg[0];
          ofs <= '0;
        end
        OP_SET_CG: begin
          cg <= 1'b1;
          ac <= {1'b0, arg[5:0]};
        end
        OP_SET_DD: begin
          cg <= 1'b0;
          ac <= arg;
        end
        OP_DATA: begin
          ac <= ac_step(ac, inc, two, cg);
          if (!arg[0] && sh && !cg) ofs <= ofs_step(ofs, inc, two);
        end
        default: ;
      endcase
    end
  end

  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_acc |=> (ac == '0 && inc && !cg && ofs == '0)); // R8
  AST_DSHIFT_HOLDS_AC: assert property (@(posedge clk) disable iff (!rst_n)
    dshift_acc |=> $stable(ac)); // R10
  AST_LINE1_TO_LINE2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_step && two && !cg && inc && ac == L1_LAST) |=> (ac == L2_FIRST)); // R6
  AST_ONE_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_step && !two && !cg && inc && ac == ONE_LAST) |=> (ac == '0)); // R5
endmodule

// File: rtl/disp_addr_ctr.sv
module disp_addr_ctr
  import dac_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [6:0] cmd_arg,
  output logic       busy,
  output logic [6:0] ac_out,
  output logic [6:0] ram_addr,
  output logic       ram_cg,
  output logic       ram_we,
  output logic       ram_re,
  output logic       fill_blank,
  output logic [6:0] disp_ofs
);
  localparam int CLR_CYCLES = DD_COUNT + BUSY_CYCLES;
  localparam int CNT_W      = $clog2(CLR_CYCLES + 1);

  dac_op_e op;
  logic acc, clr_start, data_acc;
  logic [CNT_W-1:0] busy_load;
  logic [AC_W-1:0] ac, sw_idx, d_addr;
  logic cg, sw_on, d_we, d_re, d_cg;

  assign op        = dac_op_e'(cmd_op);
  assign acc       = cmd_valid && !busy;
  assign clr_start = acc && (op == OP_CLEAR);
  assign data_acc  = acc && (op == OP_DATA);
  assign busy_load = clr_start ? CNT_W'(CLR_CYCLES) : CNT_W'(BUSY_CYCLES);

  dac_ac_core u_core (
    .clk(clk), .rst_n(rst_n), .acc(acc), .op(op), .arg(cmd_arg),
    .ac(ac), .cg(cg), .ofs(disp_ofs)
  );

  dac_busy_timer #(.CNT_W(CNT_W)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(acc), .load(busy_load), .busy(busy)
  );

  dac_clear_sweep #(.DEPTH(DD_COUNT), .W(AC_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(clr_start), .active(sw_on), .idx(sw_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_we   <= 1'b0;
      d_re   <= 1'b0;
      d_cg   <= 1'b0;
      d_addr <= '0;
    end else begin
      d_we <= data_acc && !cmd_arg[0];
      d_re <= data_acc &&  cmd_arg[0];
      if (data_acc) begin
        d_addr <= ac;
        d_cg   <= cg;
      end
    end
  end

  assign ac_out     = ac;
  assign ram_we     = sw_on | d_we;
  assign ram_re     = d_re;
  assign ram_addr   = sw_on ? sw_idx : d_addr;
  assign ram_cg     = !sw_on && d_cg;
  assign fill_blank = sw_on;

  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(ac_out)); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, ram_re})); // R4
  AST_DATA_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> (ram_we ^ ram_re)); // R4
endmodule

// File: tb/tb_disp_addr_ctr.sv
module tb_disp_addr_ctr;
  import dac_pkg::*;

  localparam int BC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [6:0] cmd_arg = '0;
  logic busy, ram_cg, ram_we, ram_re, fill_blank;
  logic [6:0] ac_out, ram_addr, disp_ofs;

  int vectors = 0, errors = 0;
  bit done = 0;

  // bench model of the state
  int m_ac = 0, m_ofs = 0;
  bit m_cg = 0, m_inc = 1, m_sh = 0, m_two = 0;

  disp_addr_ctr #(.BUSY_CYCLES(BC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .busy(busy), .ac_out(ac_out), .ram_addr(ram_addr),
    .ram_cg(ram_cg), .ram_we(ram_we), .ram_re(ram_re),
    .fill_blank(fill_blank), .disp_ofs(disp_ofs)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int b_step(int a, bit up, bit two, bit cg);
    if (cg) return (a + (up ? 1 : 63)) % 64;
    if (two) begin
      if (up) begin
        if (a == 39) return 64;
        if (a == 103) return 0;
        return (a + 1) % 128;
      end
      if (a == 64) return 39;
      if (a == 0) return 103;
      return a - 1;
    end
    if (up) return (a >= 79) ? 0 : a + 1;
    return (a == 0) ? 79 : a - 1;
  endfunction

  function automatic int b_ofs(int o, bit left, bit two);
    int len;
    len = two ? 40 : 80;
    return left ? (o + 1) % len : (o + len - 1) % len;
  endfunction

  task automatic do_cmd(input int op, input int arg, input bit poke);
    int old_ac, n, exp_busy;
    bit old_cg, rd;
    string tag;
    old_ac = m_ac; old_cg = m_cg; rd = arg[0];
    exp_busy = (op == 0) ? 80 + BC : BC;
    tag = "R3";
    case (op)
      0: begin m_ac = 0; m_cg = 0; m_inc = 1; m_ofs = 0; tag = "R8"; end
      1: begin m_ac = 0; m_cg = 0; m_ofs = 0; tag = "R9"; end
      2: begin m_inc = arg[1]; m_sh = arg[0]; tag = "R3"; end
      3: begin
        if (!arg[1]) m_ac = b_step(m_ac, arg[0], m_two, m_cg);
        else m_ofs = b_ofs(m_ofs, !arg[0], m_two);
        tag = "R10";
      end
      4: begin m_two = arg[0]; m_ofs = 0; tag = "R12"; end
      5: begin m_cg = 1; m_ac = arg % 64; tag = "R7"; end
      6: begin m_cg = 0; m_ac = arg % 128; tag = "R7"; end
      default: begin
        m_ac = b_step(m_ac, m_inc, m_two, m_cg);
        if (!rd && m_sh && !m_cg) m_ofs = b_ofs(m_ofs, m_inc, m_two);
        tag = m_cg ? "R7" : (m_two ? "R6" : "R5");
      end
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_arg = 7'(arg);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(ac_out == 7'(m_ac), tag, ac_out, m_ac);
    chk(disp_ofs == 7'(m_ofs), (op == 7) ? "R11" : tag, disp_ofs, m_ofs);
    if (op == 7) begin
      chk(ram_we == !rd && ram_re == rd, "R4", {ram_we, ram_re}, {!rd, rd});
      chk(ram_addr == 7'(old_ac) && ram_cg == old_cg && !fill_blank, "R4",
          ram_addr, old_ac);
    end else if (op != 0) begin
      chk(!ram_we && !ram_re, (op == 1) ? "R9" : "R4", {ram_we, ram_re}, 0);
    end
    n = 0;
    while (busy && n < 200) begin
      if (op == 0 && n < 80)
        chk(ram_we && fill_blank && !ram_cg && ram_addr == 7'(n), "R8", ram_addr, n);
      if (op == 0 && n == 80)
        chk(!ram_we && !fill_blank, "R8", {ram_we, fill_blank}, 0);
      if (poke && n == 1) begin
        cmd_valid = 1'b1; cmd_op = 3'(OP_SET_DD); cmd_arg = 7'h55;
      end
      @(negedge clk);
      if (poke && n == 1) begin
        cmd_valid = 1'b0;
        if (op != 0) chk(!ram_we && !ram_re, "R2", {ram_we, ram_re}, 0);
      end
      n++;
    end
    chk(n == exp_busy, "R2", n, exp_busy);
    chk(ac_out == 7'(m_ac), "R2", ac_out, m_ac);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ac_out == 0 && disp_ofs == 0, "R1", ac_out, 0);
    chk(!busy && !ram_we && !ram_re && !fill_blank, "R1",
        {busy, ram_we, ram_re, fill_blank}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 one-line wrap both ways
    do_cmd(6, 'h4F, 0); do_cmd(7, 0, 0);
    do_cmd(2, 0, 0);    do_cmd(7, 1, 0);
    // R6 two-line jumps
    do_cmd(4, 1, 0);
    do_cmd(2, 2, 0);    do_cmd(6, 'h27, 0); do_cmd(7, 0, 0);
    do_cmd(6, 'h67, 0); do_cmd(7, 0, 0);
    do_cmd(2, 0, 0);    do_cmd(6, 'h40, 0); do_cmd(7, 1, 0);
    do_cmd(6, 0, 0);    do_cmd(7, 1, 0);
    // R7 glyph RAM wrap
    do_cmd(2, 2, 0); do_cmd(5, 'h7F, 0); do_cmd(7, 0, 0);
    // R10 shifts, R11 auto-shift
    do_cmd(6, 5, 0);
    do_cmd(3, 0, 0); do_cmd(3, 1, 0); do_cmd(3, 2, 0); do_cmd(3, 3, 0); do_cmd(3, 3, 0);
    do_cmd(2, 3, 0); do_cmd(7, 0, 0); do_cmd(7, 1, 0);
    do_cmd(2, 1, 0); do_cmd(7, 0, 0);
    // R8 clear, R9 home, R2 poke while busy
    do_cmd(0, 0, 0);
    do_cmd(3, 2, 0); do_cmd(6, 9, 0); do_cmd(1, 0, 1);
    for (int i = 0; i < 300; i++) begin
      int op;
      op = ($urandom % 25 == 0) ? 0 : 1 + int'($urandom % 7);
      do_cmd(op, int'($urandom % 128), (op != 0) && ($urandom % 8 == 0));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule